// File: doc/BRIEF.md
# Serial Control Port Register Interface

This block is a serial slave port through which a host processor reads and writes a small bank of 8-bit control registers. The host drives an active-low select, a serial clock and a data line into the port. The port returns read data on an output line. Whenever select is high, the output enable is low so that the line can be parked at high impedance and shared with other devices. Every access is a pair of bytes. The first byte is an instruction that carries a read/write flag and a register address. The second byte is either the data to store or the register contents shifted back to the host.

The pair may be sent inside one select pulse of 16 serial clocks, or split into two pulses of 8 clocks each. When the access is split, the port keeps the instruction between the two pulses. Both forms give the same result. The select, serial clock and data lines are brought into the core clock domain through synchronisers, and all decoding works on edge events in that domain. The register bank is driven out as one flat bus for the rest of the chip.

Top module: `scp_port`

## Requirements
- R1: After reset, register i holds the value {i[3:0], ~i[3:0]}, and the output enable is low while select is high.
- R2: Input bits are taken on rising serial-clock edges, most significant bit first. In the instruction byte, bit 7 set to 1 means read and 0 means write. Bits [ADDR_W-1:0] give the register address. Bits 6 down to ADDR_W are ignored.
- R3: A write sent in one 16-clock pulse updates the addressed register only after select returns high. Before that, the bank is unchanged.
- R4: A write split into two 8-clock pulses has the same effect as the single-pulse form. The instruction is held between the pulses.
- R5: A read returns the addressed register, most significant bit first, over the 8 clocks that follow the instruction byte, in either form. Bit k is valid at the k-th rising edge of that byte.
- R6: Read data changes only after a falling serial-clock edge or at the end of a transaction. It holds steady while the serial clock is high.
- R7: The output enable is high exactly while select is low.
- R8: A write to an address at or above NUM_REGS changes nothing. A read from such an address returns 0x00.
- R9: When select rises after a count of serial clocks other than 8 or 16, or when a transaction goes past 16 bits, the transaction is aborted. No write happens, and the next pulse is decoded as a fresh instruction.
- R10: A read transaction leaves every register unchanged.
- R11: The data byte shifted in during a read is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from host |
| sclk | input | 1 | Serial clock from host, idles low |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Output enable for the shared data line |
| ctrl_regs | output | NUM_REGS*8 | Register bank, register i at bits [8i+7:8i] |

## Verification
The bench uses the defaults: NUM_REGS=6, ADDR_W=3 and SYNC_STAGES=2. With these values, addresses 6 and 7 decode but are not mapped, so the unmapped write and the zero read-back can be reached by ordinary random traffic. The serial clock runs at one sixteenth of the core clock, which leaves room for the two-stage synchronisers. The bench mixes split and single-pulse accesses with random values in the ignored instruction bits. It also forces aborts with pulses of 5 and 7 clocks and then shows that the next pulse decodes cleanly.

// File: rtl/scp_pkg.sv
package scp_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 5;

  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2
  } phase_e;

  // Bit 7 of the instruction selects a read.
  function automatic logic instr_is_read(input logic [BYTE_W-1:0] ib);
    return ib[BYTE_W-1];
  endfunction

  // Reset image of register idx: index nibble, then its complement.
  function automatic logic [BYTE_W-1:0] reg_reset_value(input int idx);
    logic [3:0] n;
    n = 4'(idx);
    return {n, ~n};
  endfunction

  // A select pulse is legal only for one or two whole bytes.
  function automatic logic pulse_len_ok(input logic [CNT_W-1:0] cnt);
    return (cnt == CNT_W'(BYTE_W)) || (cnt == CNT_W'(2*BYTE_W));
  endfunction

  // Saturating increment so that long pulses cannot wrap back to a legal count.
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == {CNT_W{1'b1}}) ? v : v + CNT_W'(1);
  endfunction

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int               STAGES = 2,
  parameter int               WIDTH  = 3,
  parameter logic [WIDTH-1:0] IDLE   = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out,
  output logic [WIDTH-1:0] sync_prev
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    // chain[0] is the newest sample, chain[STAGES] the previous synced value
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {(STAGES+1){IDLE[b]}};
      else        chain <= {chain[STAGES-1:0], async_in[b]};
    end
    assign sync_out[b]  = chain[STAGES-1];
    assign sync_prev[b] = chain[STAGES];
  end

endmodule

// File: rtl/scp_frame.sv
module scp_frame
  import scp_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall_ev,
  input  logic              cs_rise_ev,
  input  logic              sck_rise_ev,
  input  logic              sdi_bit,
  output phase_e            phase,
  output logic [ADDR_W-1:0] instr_addr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              instr_ld,
  output logic              xact_end
);

  logic [CNT_W-1:0]  pulse_cnt;
  logic [CNT_W-1:0]  xact_bits;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] next_byte;
  logic              len_ok;
  logic              pair_ok;
  logic              complete_ev;
  logic              abort_ev;

  assign next_byte   = {shreg[BYTE_W-2:0], sdi_bit};
  assign instr_ld    = sck_rise_ev && (phase == PH_INSTR) && (xact_bits == CNT_W'(BYTE_W-1));
  assign len_ok      = pulse_len_ok(pulse_cnt);
  assign pair_ok     = pulse_len_ok(xact_bits);
  assign complete_ev = cs_rise_ev && len_ok && (xact_bits == CNT_W'(2*BYTE_W));
  assign abort_ev    = cs_rise_ev && !(len_ok && pair_ok);
  assign xact_end    = complete_ev || abort_ev;
  assign wr_en       = complete_ev && (phase == PH_WRITE);
  assign wr_data     = shreg;

  // Clocks seen in the current select pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pulse_cnt <= '0;
    else if (cs_fall_ev)  pulse_cnt <= '0;
    else if (sck_rise_ev) pulse_cnt <= sat_inc(pulse_cnt);
  end

  // Input shift register, MSB first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           shreg <= '0;
    else if (sck_rise_ev) shreg <= next_byte;
  end

  // Transaction state survives between pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xact_bits  <= '0;
      phase      <= PH_INSTR;
      instr_addr <= '0;
    end else if (xact_end) begin
      xact_bits  <= '0;
      phase      <= PH_INSTR;
    end else if (sck_rise_ev) begin
      xact_bits <= sat_inc(xact_bits);
      if (instr_ld) begin
        instr_addr <= ADDR_W'(next_byte[BYTE_W-2:0]);
        phase      <= instr_is_read(next_byte) ? PH_READ : PH_WRITE;
      end
    end
  end

  assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> (phase == PH_INSTR) && (xact_bits == '0));

  assert_split_keeps_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise_ev && pulse_cnt == CNT_W'(BYTE_W) && xact_bits == CNT_W'(BYTE_W))
      |=> (phase == $past(phase)) && (instr_addr == $past(instr_addr)));

  assert_instr_decoded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    instr_ld |=> (phase != PH_INSTR));

endmodule

// File: rtl/scp_regfile.sv
module scp_regfile
  import scp_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter int ADDR_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [BYTE_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [BYTE_W-1:0]          rd_data,
  output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);

  logic [BYTE_W-1:0] regs_q [NUM_REGS];
  logic              wr_mapped;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  regs_q[i] <= reg_reset_value(i);
      else if (wr_en && (int'(wr_addr) == i))      regs_q[i] <= wr_data;
    end
    assign regs_flat[i*BYTE_W +: BYTE_W] = regs_q[i];
  end

  // Unmapped addresses read back as zero
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (int'(rd_addr) == i) rd_data = regs_q[i];
  end

  assign wr_mapped = int'(wr_addr) < NUM_REGS;

  assert_bank_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat));

  assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_mapped) |=> $stable(regs_flat));

endmodule

// File: rtl/scp_readout.sv
module scp_readout
  import scp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic              sck_fall_ev,
  input  logic              xact_end,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sdo_bit
);

  logic [BYTE_W-1:0] osr;
  logic              loaded;
  logic              load_ev;
  logic              shift_ev;

  // First falling edge after the instruction presents the MSB; later ones shift.
  assign load_ev  = sck_fall_ev && (phase == PH_READ) && !loaded;
  assign shift_ev = sck_fall_ev && (phase == PH_READ) && loaded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osr    <= '0;
      loaded <= 1'b0;
    end else if (xact_end) begin
      osr    <= '0;
      loaded <= 1'b0;
    end else if (load_ev) begin
      osr    <= rd_data;
      loaded <= 1'b1;
    end else if (shift_ev) begin
      osr    <= {osr[BYTE_W-2:0], 1'b0};
    end
  end

  assign sdo_bit = osr[BYTE_W-1];

  assert_sdo_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_bit) |-> $past(sck_fall_ev || xact_end));

  assert_msb_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (sdo_bit == $past(rd_data[BYTE_W-1])));

endmodule

// File: rtl/scp_port.sv
module scp_port
  import scp_pkg::*;
#(
  parameter int NUM_REGS    = 6,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       sclk,
  input  logic                       sdi,
  output logic                       sdo,
  output logic                       sdo_oe,
  output logic [NUM_REGS*BYTE_W-1:0] ctrl_regs
);

  localparam int             PIN_W   = 3;
  localparam logic [PIN_W-1:0] PIN_IDLE = 3'b001; // {sdi, sclk, cs_n}

  logic [PIN_W-1:0]  pins_s;
  logic [PIN_W-1:0]  pins_p;
  logic              cs_low;
  logic              cs_fall_ev;
  logic              cs_rise_ev;
  logic              sck_rise_ev;
  logic              sck_fall_ev;
  phase_e            phase;
  logic [ADDR_W-1:0] instr_addr;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_data;
  logic              instr_ld;
  logic              xact_end;
  logic [BYTE_W-1:0] rd_data;

  scp_sync #(.STAGES(SYNC_STAGES), .WIDTH(PIN_W), .IDLE(PIN_IDLE)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .async_in  ({sdi, sclk, cs_n}),
    .sync_out  (pins_s),
    .sync_prev (pins_p)
  );

  // Edge events in the core clock domain
  assign cs_low      = !pins_s[0];
  assign cs_fall_ev  =  pins_p[0] && !pins_s[0];
  assign cs_rise_ev  = !pins_p[0] &&  pins_s[0];
  assign sck_rise_ev = cs_low && pins_s[1] && !pins_p[1];
  assign sck_fall_ev = cs_low && !pins_s[1] && pins_p[1];

  scp_frame #(.ADDR_W(ADDR_W)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_fall_ev  (cs_fall_ev),
    .cs_rise_ev  (cs_rise_ev),
    .sck_rise_ev (sck_rise_ev),
    .sdi_bit     (pins_s[2]),
    .phase       (phase),
    .instr_addr  (instr_addr),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .instr_ld    (instr_ld),
    .xact_end    (xact_end)
  );

  scp_regfile #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (instr_addr),
    .wr_data   (wr_data),
    .rd_addr   (instr_addr),
    .rd_data   (rd_data),
    .regs_flat (ctrl_regs)
  );

  scp_readout u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase       (phase),
    .sck_fall_ev (sck_fall_ev),
    .xact_end    (xact_end),
    .rd_data     (rd_data),
    .sdo_bit     (sdo)
  );

  // The pad is released at once when select goes high
  assign sdo_oe = !cs_n;

  assert_read_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_READ) |-> !wr_en);

  assert_events_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cs_rise_ev, sck_rise_ev, instr_ld && cs_rise_ev}) <= 1);

endmodule

// File: tb/tb_scp_port.sv
module tb_scp_port;

  localparam int CLK_PERIOD = 10;
  localparam int NREG       = 6;
  localparam int HALF       = 8;
  localparam int GAP        = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cs_n = 1'b1;
  logic              sclk = 1'b0;
  logic              sdi = 1'b0;
  logic              sdo;
  logic              sdo_oe;
  logic [NREG*8-1:0] ctrl_regs;

  int compared   = 0;
  int mismatched = 0;
  bit done       = 0;
  logic [7:0] model [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  scp_port dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .ctrl_regs(ctrl_regs)
  );

  function automatic logic [7:0] exp_reset(input int i);
    int n;
    n = i % 16;
    return 8'((n << 4) | (15 - n));
  endfunction

  function automatic logic [7:0] exp_read(input int a);
    return (a < NREG) ? model[a] : 8'h00;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NREG; i++)
      check(req, 16'(ctrl_regs[i*8 +: 8]), 16'(model[i]));
  endtask

  task automatic pulse(input logic [15:0] word, input int nclk, input bit hold_chk,
                       input bit stab_chk, output logic [15:0] got);
    got = '0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    check("R7 enable while selected", 16'(sdo_oe), 16'd1);
    for (int i = 0; i < nclk; i++) begin
      sdi = word[15-i];
      got[15-i] = sdo;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      if (stab_chk) check("R6 sdo steady while sclk high", 16'(sdo), 16'(got[15-i]));
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    if (hold_chk) check_regs("R3 bank unchanged before select rises");
    cs_n = 1'b1;
    repeat (GAP) @(negedge clk);
    check("R7 enable low when deselected", 16'(sdo_oe), 16'd0);
  endtask

  task automatic xact(input bit rd, input int addr, input logic [7:0] data, input bit split);
    logic [7:0]  ib;
    logic [15:0] g1;
    logic [15:0] g2;
    logic [7:0]  rv;
    ib = {rd, 4'($urandom), 3'(addr)};
    if (split) begin
      pulse({ib, 8'h00}, 8, 1'b0, rd, g1);
      pulse({data, 8'h00}, 8, !rd, rd, g2);
      rv = g2[15:8];
    end else begin
      pulse({ib, data}, 16, !rd, rd, g1);
      rv = g1[7:0];
    end
    if (rd) begin
      check(split ? "R5 R4 split read data" : "R5 single read data", 16'(rv), 16'(exp_read(addr)));
      check_regs("R10 R11 read leaves bank unchanged");
    end else begin
      if (addr < NREG) model[addr] = data;
      check_regs(split ? "R4 split write" : "R3 R8 write effect");
    end
  endtask

  initial begin
    logic [15:0] g;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREG; i++) model[i] = exp_reset(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    check_regs("R1 reset values");
    check("R1 R7 enable low after reset", 16'(sdo_oe), 16'd0);

    // Directed corner cases
    xact(1'b0, 2, 8'hC3, 1'b0);          // R3 single write
    xact(1'b1, 2, 8'h00, 1'b1);          // R5 split read
    xact(1'b0, 5, 8'h96, 1'b1);          // R4 split write
    xact(1'b1, 5, 8'hFF, 1'b0);          // R5 R11 single read with junk data
    xact(1'b0, 7, 8'h5A, 1'b0);          // R8 unmapped write
    xact(1'b1, 6, 8'h00, 1'b1);          // R8 unmapped read gives zero
    xact(1'b1, 0, 8'hA5, 1'b0);          // R1 R5 read reset value

    // R9: short pulse aborts, next pulse is a fresh instruction
    pulse(16'h0155, 5, 1'b0, 1'b0, g);
    check_regs("R9 no write after 5-clock pulse");
    xact(1'b0, 1, 8'h3C, 1'b0);

    // R9: second byte cut to 7 clocks aborts the split write
    pulse({8'h04, 8'h00}, 8, 1'b0, 1'b0, g);
    pulse({8'hE7, 8'h00}, 7, 1'b0, 1'b0, g);
    check_regs("R9 no write after truncated second byte");
    xact(1'b1, 4, 8'h00, 1'b0);

    // R9: instruction then a 16-clock pulse exceeds two bytes
    pulse({8'h03, 8'h00}, 8, 1'b0, 1'b0, g);
    pulse(16'h7E7E, 16, 1'b0, 1'b0, g);
    check_regs("R9 no write after over-long transaction");
    xact(1'b1, 3, 8'h00, 1'b1);

    // Constrained random traffic, R2 ignored instruction bits are random
    for (int n = 0; n < 60; n++) begin
      xact(1'($urandom), int'($urandom % 8), 8'($urandom), 1'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule